// File: doc/BRIEF.md
# Multi-Mode Timer Counter Core

This block is a timer counter with a parameterised width (16 bits by default). Its count clock comes from one of three sources: the core clock, an external clock pin sampled for rising edges, or the rising edges of a trigger line picked from a small trigger bus. It can also take its count clock from a two-phase quadrature encoder. The selected clock passes through a programmable divider before it steps the counter. The counter counts up, counts down, or sweeps up and down between zero and a buffered period. Both the period and the divider value are written into shadow registers and only become active at the next update event.

A slave controller watches the selected trigger line. Depending on its mode it can clear the counter on a trigger edge, let the counter run only while the trigger is high, or hold the counter until a trigger edge starts it. The block signals each update (period boundary, software request or trigger clear) with a one-cycle pulse. It signals each trigger edge seen by an active slave mode with a pulse. It also drives a trigger output for neighbouring timers or converters, and it presents the current count.

Top module: `mm_timer_core`

## Requirements
- R1: After reset the count is 0, `update_evt`, `trig_evt` and `trig_out` are low, the divider is 1 and the period is all ones. With the core clock selected, the count therefore rises by one per cycle and does not wrap within the first 300 cycles.
- R2: With `count_mode` = 0 (up), each count step adds one. A step taken at or above the active period instead wraps the count to 0 and pulses `update_evt`.
- R3: With `count_mode` = 1 (down), each step subtracts one. A step taken at 0 instead loads the period and pulses `update_evt`.
- R4: With `count_mode` = 2 (up/down), the count climbs to the period and then descends to 0. It turns at each end, and each turn is a step that moves it one away from that end and pulses `update_evt`.
- R5: With `count_mode` = 3 (encoder), the divider is fed by each change of exactly one of `enc_a`/`enc_b` (four steps per quadrature cycle). The direction is up when `enc_a` leads `enc_b` (states 00,10,11,01) and down in reverse. Wrapping follows R2 going up and R3 going down.
- R6: Outside encoder mode, `clk_src` selects the count clock: 0 or 3 means every core cycle, 1 means each rising edge of `ext_clk`, and 2 means each rising edge of `trig_in[trig_sel]`. Edges on unselected trigger lines have no effect.
- R7: With divider value D written via `wr_prescale`, the counter steps once per D+1 count clocks. The divider phase restarts at every update event, and a newly written D takes effect only from the next update event.
- R8: A period written via `wr_period` goes to a shadow register. The counter keeps using the previous period until the next update event.
- R9: A `sw_update` pulse while enabled forces an update event. On the next cycle `update_evt` is high and the count is 0, or equals the shadow period in down mode. The shadow period and divider become active at the same time.
- R10: With `slave_mode` = 1 (reset), a rising edge on the selected trigger clears the count exactly like R9. A trigger held high causes no further clears.
- R11: With `slave_mode` = 2 (hang), the counter steps only while the selected trigger is high and holds its value while it is low.
- R12: With `slave_mode` = 3 (start), the counter holds until a rising edge of the selected trigger and steps from the following cycle on, even after the trigger falls.
- R13: When the slave mode is not 0, each rising edge of the selected trigger pulses `trig_evt` one cycle later. With the default trigger-output option, `trig_out` mirrors `update_evt`.
- R14: While `enable` is low the count holds its value, and no `update_evt` or `trig_evt` pulse occurs, even on `sw_update` or trigger edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Counter enable; low freezes count and events |
| sw_update | input | 1 | Software request for an update event |
| count_mode | input | 2 | 0 up, 1 down, 2 up/down, 3 encoder |
| clk_src | input | 2 | Count clock: 0/3 core, 1 external pin, 2 selected trigger |
| slave_mode | input | 2 | 0 off, 1 reset, 2 hang, 3 start |
| trig_sel | input | $clog2(NTRIG) | Index of the trigger line in use |
| trig_in | input | NTRIG | Trigger lines from other blocks |
| ext_clk | input | 1 | External clock, synchronous level |
| enc_a | input | 1 | Encoder phase A |
| enc_b | input | 1 | Encoder phase B |
| wr_period | input | 1 | Write strobe for the period shadow |
| wr_prescale | input | 1 | Write strobe for the divider shadow |
| wr_data | input | CNT_W | Write data for both shadows |
| count | output | CNT_W | Current count |
| update_evt | output | 1 | One-cycle update event pulse |
| trig_evt | output | 1 | One-cycle trigger event pulse |
| trig_out | output | 1 | Trigger output to neighbours |

## Verification
The hardest state to reach from the ports is a divider or period change that is pending while the old values are still in force. The stimulus writes a new divider or period one cycle after a forced update, so the write lands in the middle of a period. It then follows the count cycle by cycle across the next wrap and checks that the old rate or period holds right up to the boundary and the new one applies after it. The encoder case is driven through forward and reverse quadrature runs that cross zero in both directions. This checks that a reversal at zero reloads the period rather than underflowing.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
   typedef enum logic [1:0] {
      CM_UP     = 2'd0,
      CM_DOWN   = 2'd1,
      CM_CENTER = 2'd2,
      CM_QUAD   = 2'd3
   } cnt_mode_e;

   typedef enum logic [1:0] {
      CS_CORE  = 2'd0,
      CS_PIN   = 2'd1,
      CS_TRIG  = 2'd2,
      CS_CORE2 = 2'd3
   } clk_src_e;

   typedef enum logic [1:0] {
      SL_OFF   = 2'd0,
      SL_RESET = 2'd1,
      SL_HANG  = 2'd2,
      SL_START = 2'd3
   } slave_mode_e;
endpackage

// File: rtl/tmr_tick_gen.sv
`timescale 1ns/1ps
module tmr_tick_gen
   import tmr_pkg::*;
#(
   parameter int NTRIG   = 4,
   parameter bit QUAD_EN = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [1:0]               clk_src,
   input  logic                     quad_mode,
   input  logic                     ext_clk,
   input  logic [NTRIG-1:0]         trig_in,
   input  logic [$clog2(NTRIG)-1:0] trig_sel,
   input  logic                     enc_a,
   input  logic                     enc_b,
   output logic                     tick,
   output logic                     quad_up,
   output logic                     trig_lvl,
   output logic                     trig_rise
);
   logic ext_q, trig_q, ext_rise, quad_step;

   assign trig_lvl  = trig_in[trig_sel];
   assign trig_rise = trig_lvl & ~trig_q;
   assign ext_rise  = ext_clk & ~ext_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_q  <= 1'b0;
         trig_q <= 1'b0;
      end else begin
         ext_q  <= ext_clk;
         trig_q <= trig_lvl;
      end
   end

   if (QUAD_EN) begin : g_quad
      logic a_q, b_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            a_q <= 1'b0;
            b_q <= 1'b0;
         end else begin
            a_q <= enc_a;
            b_q <= enc_b;
         end
      end
      // exactly one phase moved: a valid quadrature step
      assign quad_step = (enc_a ^ a_q) ^ (enc_b ^ b_q);
      assign quad_up   = enc_a ^ b_q;
   end else begin : g_noquad
      assign quad_step = 1'b0;
      assign quad_up   = 1'b1;
   end

   always_comb begin
      if (quad_mode) tick = quad_step;
      else begin
         case (clk_src_e'(clk_src))
            CS_PIN:  tick = ext_rise;
            CS_TRIG: tick = trig_rise;
            default: tick = 1'b1;
         endcase
      end
   end
endmodule

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler #(
   parameter int PSC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_psc,
   input  logic [PSC_W-1:0] wr_data,
   input  logic             tick_in,
   input  logic             reload,
   output logic             cnt_en
);
   localparam logic [PSC_W-1:0] P_ONE = PSC_W'(1);
   logic [PSC_W-1:0] psc_pre, psc_act, psc_cnt;

   assign cnt_en = tick_in && (psc_cnt == psc_act);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         psc_pre <= '0;
         psc_act <= '0;
         psc_cnt <= '0;
      end else begin
         if (wr_psc) psc_pre <= wr_data;
         if (reload) begin
            psc_act <= psc_pre;
            psc_cnt <= '0;
         end else if (tick_in) begin
            psc_cnt <= cnt_en ? '0 : psc_cnt + P_ONE;
         end
      end
   end
endmodule

// File: rtl/tmr_count_core.sv
`timescale 1ns/1ps
module tmr_count_core
   import tmr_pkg::*;
#(
   parameter int               CNT_W      = 16,
   parameter logic [CNT_W-1:0] PERIOD_RST = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode,
   input  logic             step,
   input  logic             quad_up,
   input  logic             force_upd,
   input  logic             reload,
   input  logic             wr_per,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] count,
   output logic             wrap
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
   logic [CNT_W-1:0] per_pre, per_act;
   logic             dir_dn, at_top, at_bot;

   assign at_top = (count >= per_act);
   assign at_bot = (count == '0);

   always_comb begin
      case (cnt_mode_e'(mode))
         CM_UP:     wrap = step & at_top;
         CM_DOWN:   wrap = step & at_bot;
         CM_CENTER: wrap = step & (dir_dn ? at_bot : at_top);
         default:   wrap = step & (quad_up ? at_top : at_bot);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count   <= '0;
         dir_dn  <= 1'b0;
         per_pre <= PERIOD_RST;
         per_act <= PERIOD_RST;
      end else begin
         if (wr_per) per_pre <= wr_data;
         if (reload) per_act <= per_pre;
         if (force_upd) begin
            count  <= (cnt_mode_e'(mode) == CM_DOWN) ? per_pre : '0;
            dir_dn <= 1'b0;
         end else if (step) begin
            case (cnt_mode_e'(mode))
               CM_UP:   count <= at_top ? '0 : count + ONE;
               CM_DOWN: count <= at_bot ? per_pre : count - ONE;
               CM_CENTER: begin
                  if (dir_dn) begin
                     if (at_bot) begin
                        dir_dn <= 1'b0;
                        count  <= (per_act == '0) ? '0 : ONE;
                     end else count <= count - ONE;
                  end else begin
                     if (at_top) begin
                        dir_dn <= 1'b1;
                        count  <= (per_act == '0) ? '0 : per_act - ONE;
                     end else count <= count + ONE;
                  end
               end
               default: begin
                  if (quad_up) count <= at_top ? '0 : count + ONE;
                  else         count <= at_bot ? per_pre : count - ONE;
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/mm_timer_core.sv
`timescale 1ns/1ps
module mm_timer_core
   import tmr_pkg::*;
#(
   parameter int               CNT_W      = 16,
   parameter int               PSC_W      = 16,
   parameter int               NTRIG      = 4,
   parameter bit               QUAD_EN    = 1'b1,
   parameter int               TRGO_SEL   = 0,
   parameter logic [CNT_W-1:0] PERIOD_RST = '1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     enable,
   input  logic                     sw_update,
   input  logic [1:0]               count_mode,
   input  logic [1:0]               clk_src,
   input  logic [1:0]               slave_mode,
   input  logic [$clog2(NTRIG)-1:0] trig_sel,
   input  logic [NTRIG-1:0]         trig_in,
   input  logic                     ext_clk,
   input  logic                     enc_a,
   input  logic                     enc_b,
   input  logic                     wr_period,
   input  logic                     wr_prescale,
   input  logic [CNT_W-1:0]         wr_data,
   output logic [CNT_W-1:0]         count,
   output logic                     update_evt,
   output logic                     trig_evt,
   output logic                     trig_out
);
   if (CNT_W < 2)                     begin : g_bad_cnt  $error("CNT_W must be at least 2");        end
   if (PSC_W < 1 || PSC_W > CNT_W)    begin : g_bad_psc  $error("PSC_W must lie in 1..CNT_W");      end
   if (NTRIG < 2)                     begin : g_bad_trg  $error("NTRIG must be at least 2");        end
   if (TRGO_SEL != 0 && TRGO_SEL != 1) begin : g_bad_tgo $error("TRGO_SEL must be 0 or 1");         end

   logic tick, quad_up, trig_lvl, trig_rise;
   logic run, started, force_upd, step, wrap, upd;

   tmr_tick_gen #(.NTRIG(NTRIG), .QUAD_EN(QUAD_EN)) u_tick (
      .clk       (clk),
      .rst_n     (rst_n),
      .clk_src   (clk_src),
      .quad_mode (count_mode == CM_QUAD),
      .ext_clk   (ext_clk),
      .trig_in   (trig_in),
      .trig_sel  (trig_sel),
      .enc_a     (enc_a),
      .enc_b     (enc_b),
      .tick      (tick),
      .quad_up   (quad_up),
      .trig_lvl  (trig_lvl),
      .trig_rise (trig_rise)
   );

   // slave controller: decides whether count clocks may pass
   always_comb begin
      case (slave_mode_e'(slave_mode))
         SL_HANG:  run = enable & trig_lvl;
         SL_START: run = enable & started;
         default:  run = enable;
      endcase
   end

   assign force_upd = enable & (sw_update | ((slave_mode == SL_RESET) & trig_rise));
   assign upd       = force_upd | wrap;

   tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_psc  (wr_prescale),
      .wr_data (wr_data[PSC_W-1:0]),
      .tick_in (tick & run),
      .reload  (upd),
      .cnt_en  (step)
   );

   tmr_count_core #(.CNT_W(CNT_W), .PERIOD_RST(PERIOD_RST)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (count_mode),
      .step      (step),
      .quad_up   (quad_up),
      .force_upd (force_upd),
      .reload    (upd),
      .wr_per    (wr_period),
      .wr_data   (wr_data),
      .count     (count),
      .wrap      (wrap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         started    <= 1'b0;
         update_evt <= 1'b0;
         trig_evt   <= 1'b0;
      end else begin
         if (!enable || slave_mode != SL_START) started <= 1'b0;
         else if (trig_rise)                    started <= 1'b1;
         update_evt <= upd;
         trig_evt   <= enable & (slave_mode != SL_OFF) & trig_rise;
      end
   end

   if (TRGO_SEL == 0) begin : g_trgo_upd
      assign trig_out = update_evt;
   end else begin : g_trgo_run
      logic run_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) run_q <= 1'b0;
         else        run_q <= run;
      end
      assign trig_out = run_q;
   end
endmodule

// File: rtl/tmr_core_chk.sv
`timescale 1ns/1ps
module tmr_core_chk #(
   parameter int CNT_W = 16,
   parameter int NTRIG = 4
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     enable,
   input logic                     sw_update,
   input logic [1:0]               count_mode,
   input logic [1:0]               slave_mode,
   input logic [$clog2(NTRIG)-1:0] trig_sel,
   input logic [NTRIG-1:0]         trig_in,
   input logic [CNT_W-1:0]         count,
   input logic                     update_evt,
   input logic                     trig_evt
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
   logic sel_lvl;
   assign sel_lvl = trig_in[trig_sel];

   AST_FROZEN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> $stable(count)); // R14
   AST_FROZEN_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !update_evt); // R14
   AST_FROZEN_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !trig_evt); // R14
   AST_SW_UPDATE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && sw_update) |=> update_evt); // R9
   AST_SW_UPDATE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && sw_update && count_mode != 2'd1) |=> (count == '0)); // R9
   AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (count_mode == 2'd0) |=> (count == '0 || $stable(count) || count == $past(count) + ONE)); // R2
   AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (count_mode == 2'd1 && !sw_update && slave_mode != 2'd1)
         |=> ($stable(count) || count == $past(count) - ONE || $past(count) == '0)); // R3
   AST_HANG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (slave_mode == 2'd2 && !sel_lvl && !sw_update) |=> $stable(count)); // R11
endmodule

bind mm_timer_core tmr_core_chk #(.CNT_W(CNT_W), .NTRIG(NTRIG)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .enable     (enable),
   .sw_update  (sw_update),
   .count_mode (count_mode),
   .slave_mode (slave_mode),
   .trig_sel   (trig_sel),
   .trig_in    (trig_in),
   .count      (count),
   .update_evt (update_evt),
   .trig_evt   (trig_evt)
);

// File: tb/test_mm_timer_core.sv
`timescale 1ns/1ps
module test_mm_timer_core;
   localparam int CNT_W = 16;
   localparam int NTRIG = 4;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             enable, sw_update, ext_clk, enc_a, enc_b;
   logic             wr_period, wr_prescale;
   logic [1:0]       count_mode, clk_src, slave_mode;
   logic [1:0]       trig_sel;
   logic [NTRIG-1:0] trig_in;
   logic [CNT_W-1:0] wr_data, count;
   logic             update_evt, trig_evt, trig_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   mm_timer_core #(.CNT_W(CNT_W), .NTRIG(NTRIG)) i_mm_timer_core (
      .clk(clk), .rst_n(rst_n), .enable(enable), .sw_update(sw_update),
      .count_mode(count_mode), .clk_src(clk_src), .slave_mode(slave_mode),
      .trig_sel(trig_sel), .trig_in(trig_in), .ext_clk(ext_clk),
      .enc_a(enc_a), .enc_b(enc_b), .wr_period(wr_period),
      .wr_prescale(wr_prescale), .wr_data(wr_data), .count(count),
      .update_evt(update_evt), .trig_evt(trig_evt), .trig_out(trig_out)
   );

   task automatic check(input string req, input int act, input int exp_v);
      checks++;
      if (act != exp_v) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp_v);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_psc(input int v);
      wr_prescale = 1'b1; wr_data = CNT_W'(v);
      @(negedge clk);
      wr_prescale = 1'b0;
   endtask

   task automatic write_per(input int v);
      wr_period = 1'b1; wr_data = CNT_W'(v);
      @(negedge clk);
      wr_period = 1'b0;
   endtask

   task automatic force_update();
      sw_update = 1'b1;
      @(negedge clk);
      sw_update = 1'b0;
   endtask

   int qstate = 0;
   int qpos   = 0;
   task automatic quad_move(input int dir, input int per);
      qstate = (qstate + dir + 4) % 4;
      case (qstate)
         0: {enc_a, enc_b} = 2'b00;
         1: {enc_a, enc_b} = 2'b10;
         2: {enc_a, enc_b} = 2'b11;
         default: {enc_a, enc_b} = 2'b01;
      endcase
      qpos += dir;
      @(negedge clk);
      check("R5 encoder position", int'(count), ((qpos % (per + 1)) + per + 1) % (per + 1));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: got 0 expected 1 (run completed)");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; enable = 1'b0; sw_update = 1'b0; ext_clk = 1'b0;
      enc_a = 1'b0; enc_b = 1'b0; wr_period = 1'b0; wr_prescale = 1'b0;
      count_mode = 2'd0; clk_src = 2'd0; slave_mode = 2'd0; trig_sel = 2'd0;
      trig_in = '0; wr_data = '0;
      cyc(3);
      rst_n = 1'b1;
      // R1 reset state
      check("R1 count", int'(count), 0);
      check("R1 update_evt", int'(update_evt), 0);
      check("R1 trig_evt", int'(trig_evt), 0);
      check("R1 trig_out", int'(trig_out), 0);
      enable = 1'b1;
      cyc(300);
      check("R1 divide-by-one, full period", int'(count), 300);

      // R2 R3 R4 R7 R9 sweeps over mode, period and divider
      for (int m = 0; m < 3; m++) begin
         for (int p = 1; p <= 4; p++) begin
            for (int d = 0; d <= 2; d++) begin
               int flags, nmax, s, r, ex, exf;
               string tag;
               tag = (m == 0) ? "R2 R7 up" : (m == 1) ? "R3 R7 down" : "R4 R7 updown";
               count_mode = 2'(m);
               write_psc(d);
               write_per(p);
               force_update();
               check("R9 forced update pulse", int'(update_evt), 1);
               check("R9 forced count value", int'(count), (m == 1) ? p : 0);
               flags = 0;
               nmax  = 3 * (p + 1) * (d + 1) + 2;
               for (int n = 1; n <= nmax; n++) begin
                  @(negedge clk);
                  s = n / (d + 1);
                  if (m == 0) ex = s % (p + 1);
                  else if (m == 1) ex = p - (s % (p + 1));
                  else begin
                     r  = s % (2 * p);
                     ex = (r <= p) ? r : 2 * p - r;
                  end
                  check(tag, int'(count), ex);
                  flags += int'(update_evt);
               end
               s = nmax / (d + 1);
               if (m == 2) exf = (s == 0) ? 0 : (s - 1) / p;
               else        exf = s / (p + 1);
               check({tag, " update pulses"}, flags, exf);
            end
         end
      end

      // R5 encoder
      count_mode = 2'd3;
      write_psc(0);
      write_per(5);
      force_update();
      qpos = 0;
      for (int i = 0; i < 14; i++) quad_move(1, 5);
      cyc(3);
      check("R5 encoder idle hold", int'(count), ((qpos % 6) + 6) % 6);
      for (int i = 0; i < 20; i++) quad_move(-1, 5);
      for (int i = 0; i < 3; i++)  quad_move(1, 5);

      // R6 external clock pin
      count_mode = 2'd0;
      clk_src = 2'd1;
      write_per(7);
      force_update();
      for (int e = 1; e <= 10; e++) begin
         ext_clk = 1'b1; cyc(2);
         ext_clk = 1'b0; cyc(3);
         check("R6 ext clock edges", int'(count), e % 8);
      end

      // R6 trigger line as clock, with an unselected line toggling
      begin
         int tev;
         tev = 0;
         clk_src  = 2'd2;
         trig_sel = 2'd2;
         force_update();
         for (int e = 1; e <= 9; e++) begin
            trig_in[2] = 1'b1; @(negedge clk); tev += int'(trig_evt);
            trig_in[2] = 1'b0; @(negedge clk); tev += int'(trig_evt);
            trig_in[1] = 1'b1; @(negedge clk); tev += int'(trig_evt);
            trig_in[1] = 1'b0; @(negedge clk); tev += int'(trig_evt);
            check("R6 trigger clock edges", int'(count), e % 8);
         end
         check("R13 no trig_evt with slave off", tev, 0);
      end
      clk_src  = 2'd0;
      trig_sel = 2'd0;

      // R7 divider change waits for the boundary
      write_psc(0);
      write_per(3);
      force_update();
      write_psc(2);
      check("R7 old divider still active", int'(count), 1);
      for (int n = 2; n <= 13; n++) begin
         @(negedge clk);
         check("R7 divider switch at boundary", int'(count), (n <= 3) ? n : ((n - 4) / 3) % 4);
      end

      // R8 period change waits for the boundary
      write_psc(0);
      write_per(5);
      force_update();
      write_per(2);
      check("R8 old period still active", int'(count), 1);
      for (int n = 2; n <= 12; n++) begin
         @(negedge clk);
         check("R8 period switch at boundary", int'(count), (n <= 5) ? n : (n - 6) % 3);
      end

      // R10 reset slave mode, R13 trigger pulses
      write_per(200);
      slave_mode = 2'd1;
      force_update();
      cyc(10);
      check("R10 running before trigger", int'(count), 10);
      trig_in[0] = 1'b1;
      @(negedge clk);
      check("R10 trigger clears count", int'(count), 0);
      check("R10 trigger update pulse", int'(update_evt), 1);
      check("R13 trig_evt pulse", int'(trig_evt), 1);
      check("R13 trig_out mirrors update", int'(trig_out), 1);
      @(negedge clk);
      check("R10 counting resumes", int'(count), 1);
      check("R13 trig_evt single cycle", int'(trig_evt), 0);
      cyc(5);
      check("R10 held trigger no reclear", int'(count), 6);
      trig_in[0] = 1'b0;

      // R11 hang slave mode
      slave_mode = 2'd2;
      force_update();
      cyc(5);
      check("R11 hold while trigger low", int'(count), 0);
      trig_in[0] = 1'b1;
      cyc(5);
      check("R11 count while trigger high", int'(count), 5);
      trig_in[0] = 1'b0;
      cyc(4);
      check("R11 hold after trigger falls", int'(count), 5);

      // R12 start slave mode
      slave_mode = 2'd3;
      force_update();
      cyc(4);
      check("R12 wait for trigger", int'(count), 0);
      trig_in[0] = 1'b1;
      @(negedge clk);
      check("R12 edge cycle no step", int'(count), 0);
      check("R13 trig_evt in start mode", int'(trig_evt), 1);
      cyc(4);
      check("R12 counting after start", int'(count), 4);
      trig_in[0] = 1'b0;
      cyc(3);
      check("R12 keeps counting after fall", int'(count), 7);

      // R14 enable low
      begin
         int held;
         slave_mode = 2'd1;
         held = int'(count);
         enable = 1'b0;
         @(negedge clk);
         check("R14 count frozen", int'(count), held);
         sw_update = 1'b1;
         @(negedge clk);
         sw_update = 1'b0;
         check("R14 sw_update ignored", int'(update_evt), 0);
         check("R14 count after sw_update", int'(count), held);
         trig_in[0] = 1'b1;
         @(negedge clk);
         check("R14 trigger ignored", int'(trig_evt), 0);
         check("R14 count after trigger", int'(count), held);
         cyc(5);
         check("R14 still frozen", int'(count), held);
         check("R14 no update pulse", int'(update_evt), 0);
         trig_in[0] = 1'b0;
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule